// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single memory access may proceed, judged against sixteen protection regions. Each region has an address register and an eight-bit configuration field. The configuration selects how the region is matched: disabled, a top-of-range window bounded by the previous region's address, a naturally aligned 4-byte word, or a naturally aligned power-of-two block. It also holds read, write and execute permissions and a lock flag. A simple write port loads the address registers and the packed configuration registers. There is no readback path.

An access carries an address, a length of 1 to 8 bytes, a kind (read, write or fetch) and a privilege flag (machine or user). The access is cut into 4-byte granules starting at its address. The lowest-numbered enabled region that matches any granule decides the outcome. If that region covers only some of the granules, the access is refused. A refused access returns a fault with cause code 1 and the address of the access.

Requests enter through a valid/ready channel and results leave through another. With the output stage enabled (the default), a request accepted on one edge produces its result after that edge. The request side is ready whenever the result register is empty or is being drained that cycle. While the consumer holds ready low, the result stays frozen and no new request is taken. With the stage disabled, the decision is purely combinational, and ready passes straight through from the result side to the request side.

Top module: `pmp_checker`

## Requirements
- R1: After reset every region is disabled and every address register is zero, so a machine access is allowed and a user access is refused. The result channel reports nothing until a request is accepted.
- R2: Configuration register k carries the fields of regions 4k to 4k+3, with region i in byte i mod 4 (bits 8*(i mod 4)+7 down to 8*(i mod 4)). Within a byte: bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = match mode, bit 7 = lock. Bits 6:5 are ignored.
- R3: In mode 1 (top-of-range), a granule matches when its address is at least the previous region's register times 4 and below this region's register times 4. Region 0 uses zero as its lower bound. The bound is taken from the previous register whatever that region's mode is.
- R4: In mode 2, a region matches the 4 bytes whose address bits above bit 1 equal those of the register times 4.
- R5: In mode 3, a register whose low bits hold t trailing ones covers 2^(t+3) bytes aligned to that size. The register's remaining upper bits give the base.
- R6: An access of length n is tested as ceil(n/4) granules, at the access address plus 0 and plus 4. If the deciding region matches some but not all granules, the access is refused.
- R7: Regions are scanned from index 0 upward, and only the lowest-numbered region that matches at least one granule decides the outcome.
- R8: The deciding region allows the access when the privilege is machine and its lock bit is clear, or when its permission bit for the access kind is set. Kind encoding: 0 = read, 1 = write, 2 = fetch; code 3 has no permission bit.
- R9: When no region matches, the access is allowed for machine privilege only.
- R10: A refused result shows fault = 1, fault code = 1 and fault address = the access address. An allowed result shows fault = 0, code 0 and address 0.
- R11: With the output stage, the result appears on the edge that accepts the request. The request-side ready equals (no result held) or (result side ready), and a held result keeps its value until it is taken.
- R12: A region in mode 0 never matches, whatever its address or permission bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a configuration register |
| cfg_sel | input | 2 | Which configuration register to write |
| cfg_wdata | input | 32 | Four packed region configuration bytes |
| addr_we | input | 1 | Write strobe for a region address register |
| addr_sel | input | 4 | Which region address register to write |
| addr_wdata | input | 30 | Region address shifted right by two |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 32 | Access byte address |
| req_len | input | 4 | Access length in bytes, 1 to 8 |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv_m | input | 1 | 1 for machine privilege, 0 for user |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access refused |
| rsp_fault_code | output | 4 | Fault cause, 1 on refusal |
| rsp_fault_addr | output | 32 | Address of the refused access |

## Verification
The assertions assume that request fields are stable and defined on every clock edge after reset. They also assume a length from 1 to 8 bytes, so that at least one granule is live and none beyond the second is implied. They further assume that the sixteen regions are programmed only through the write port, never mid-request by another path. The stimulus drives every input on the falling edge, and it writes the regions before issuing any request that depends on them. It keeps lengths within that range and never lets granule addresses wrap past the top of the address space.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  // Match-mode encoding held in configuration bits 4:3
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_WORD4 = 2'd2,
    MODE_POW2  = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;

  // Stored form of one region's configuration byte (reserved bits dropped)
  typedef struct packed {
    logic        lock;
    match_mode_e mode;
    logic        perm_x;
    logic        perm_w;
    logic        perm_r;
  } region_cfg_t;

  localparam int unsigned GRAN_BYTES   = 4;
  localparam int unsigned FIELDS_PER_REG = 4;
  localparam logic [3:0]  DENY_CAUSE   = 4'd1;

endpackage

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_chk_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned CFG_REGS = ENTRIES / FIELDS_PER_REG,
  localparam int unsigned CSEL_W   = (CFG_REGS > 1) ? $clog2(CFG_REGS) : 1,
  localparam int unsigned ESEL_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned RA_W     = ADDR_W - 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CSEL_W-1:0]        cfg_sel,
  input  logic [31:0]              cfg_wdata,
  input  logic                     addr_we,
  input  logic [ESEL_W-1:0]        addr_sel,
  input  logic [RA_W-1:0]          addr_wdata,
  output region_cfg_t              ent_cfg  [ENTRIES],
  output logic [RA_W-1:0]          ent_addr [ENTRIES]
);

  // Reserved bits 6:5 of every byte carry no state
  logic unused_rsvd;
  assign unused_rsvd = ^{cfg_wdata[30:29], cfg_wdata[22:21],
                         cfg_wdata[14:13], cfg_wdata[6:5]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam int unsigned REG_IX = e / FIELDS_PER_REG;
    localparam int unsigned LSB    = 8 * (e % FIELDS_PER_REG);
    region_cfg_t cfg_q;
    logic [RA_W-1:0] addr_q;

    // R2: region e lives in byte (e mod 4) of register e/4
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cfg_we && (cfg_sel == CSEL_W'(REG_IX))) begin
        cfg_q.lock   <= cfg_wdata[LSB+7];
        cfg_q.mode   <= match_mode_e'(cfg_wdata[LSB+4 -: 2]);
        cfg_q.perm_x <= cfg_wdata[LSB+2];
        cfg_q.perm_w <= cfg_wdata[LSB+1];
        cfg_q.perm_r <= cfg_wdata[LSB];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
      end else if (addr_we && (addr_sel == ESEL_W'(e))) begin
        addr_q <= addr_wdata;
      end
    end

    assign ent_cfg[e]  = cfg_q;
    assign ent_addr[e] = addr_q;

    p_cfg_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == CSEL_W'(REG_IX)) |=>
        (ent_cfg[e].lock == $past(cfg_wdata[LSB+7]) &&
         ent_cfg[e].perm_r == $past(cfg_wdata[LSB])));

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == CSEL_W'(REG_IX)) |=> $stable(ent_cfg[e]));

    p_addr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_we && addr_sel == ESEL_W'(e)) |=> ent_addr[e] == $past(addr_wdata));
  end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned GRAN   = 2,
  localparam int unsigned RA_W  = ADDR_W - 2
) (
  input  match_mode_e          mode,
  input  logic [RA_W-1:0]      top_reg,
  input  logic [RA_W-1:0]      base_reg,
  input  logic [ADDR_W-1:0]    gran_addr [GRAN],
  input  logic [GRAN-1:0]      gran_live,
  output logic                 any_hit,
  output logic                 all_hit
);

  logic [ADDR_W-1:0] top_byte;
  logic [ADDR_W-1:0] base_byte;
  logic [RA_W:0]     mask_src;
  logic [RA_W:0]     trail_ones;
  logic [ADDR_W-1:0] keep_mask;
  logic [GRAN-1:0]   hit;

  assign top_byte  = {top_reg, 2'b00};
  assign base_byte = {base_reg, 2'b00};

  // R4/R5: the 4-byte mode forces zero trailing ones; the power-of-two
  // mode appends a one so t trailing ones give 2^(t+3) bytes.
  assign mask_src   = {top_reg, (mode != MODE_WORD4)};
  assign trail_ones = mask_src & ~(mask_src + 1'b1);
  assign keep_mask  = {~trail_ones[RA_W-1:0], 2'b00};

  for (genvar g = 0; g < GRAN; g++) begin : g_gran
    logic tor_hit;
    logic aligned_hit;
    // R3: half-open window [base, top)
    assign tor_hit     = (gran_addr[g] >= base_byte) && (gran_addr[g] < top_byte);
    assign aligned_hit = ((gran_addr[g] ^ top_byte) & keep_mask) == '0;
    always_comb begin
      unique case (mode)
        MODE_TOR:               hit[g] = tor_hit;
        MODE_WORD4, MODE_POW2:  hit[g] = aligned_hit;
        default:                hit[g] = 1'b0;  // R12
      endcase
    end
  end

  // R6: only live granules count toward either flag
  assign any_hit = |(hit & gran_live);
  assign all_hit = &(hit | ~gran_live);

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
  import pmp_chk_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] any_vec,
  input  logic [ENTRIES-1:0] all_vec,
  input  region_cfg_t        ent_cfg [ENTRIES],
  input  logic               priv_m,
  input  acc_kind_e          kind,
  output logic [ENTRIES-1:0] win_vec,
  output logic               allow
);

  logic [ENTRIES-1:0] perm_vec;
  logic [ENTRIES-1:0] lock_vec;
  logic found;
  logic win_full;
  logic win_lock;
  logic win_perm;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_perm
    assign lock_vec[e] = ent_cfg[e].lock;
    always_comb begin
      unique case (kind)
        KIND_READ:  perm_vec[e] = ent_cfg[e].perm_r;
        KIND_WRITE: perm_vec[e] = ent_cfg[e].perm_w;
        KIND_FETCH: perm_vec[e] = ent_cfg[e].perm_x;
        default:    perm_vec[e] = 1'b0;
      endcase
    end
  end

  // R7: lowest index with any granule hit wins
  always_comb begin
    win_vec = '0;
    found   = 1'b0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (!found && any_vec[i]) begin
        win_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign win_full = |(win_vec & all_vec);
  assign win_lock = |(win_vec & lock_vec);
  assign win_perm = |(win_vec & perm_vec);

  // R6, R8, R9
  assign allow = found ? (win_full && ((priv_m && !win_lock) || win_perm))
                       : priv_m;

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_chk_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_BYTES = 8,
  parameter bit          REG_OUT   = 1'b1,
  localparam int unsigned GRAN     = (MAX_BYTES + GRAN_BYTES - 1) / GRAN_BYTES,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned CFG_REGS = ENTRIES / FIELDS_PER_REG,
  localparam int unsigned CSEL_W   = (CFG_REGS > 1) ? $clog2(CFG_REGS) : 1,
  localparam int unsigned ESEL_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned RA_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CSEL_W-1:0] cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              addr_we,
  input  logic [ESEL_W-1:0] addr_sel,
  input  logic [RA_W-1:0]   addr_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_kind,
  input  logic              req_priv_m,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic              rsp_fault,
  output logic [3:0]        rsp_fault_code,
  output logic [ADDR_W-1:0] rsp_fault_addr
);

  region_cfg_t       ent_cfg  [ENTRIES];
  logic [RA_W-1:0]   ent_addr [ENTRIES];
  logic [RA_W-1:0]   ent_base [ENTRIES];
  logic [ADDR_W-1:0] gran_addr [GRAN];
  logic [GRAN-1:0]   gran_live;
  logic [ENTRIES-1:0] any_vec;
  logic [ENTRIES-1:0] all_vec;
  logic [ENTRIES-1:0] win_vec;
  logic              dec_allow;
  logic              nxt_fault;
  logic [3:0]        nxt_code;
  logic [ADDR_W-1:0] nxt_faddr;

  pmp_csr_bank #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .addr_we    (addr_we),
    .addr_sel   (addr_sel),
    .addr_wdata (addr_wdata),
    .ent_cfg    (ent_cfg),
    .ent_addr   (ent_addr)
  );

  // R6: granule g sits at addr + 4g and is live when len > 4g
  for (genvar g = 0; g < GRAN; g++) begin : g_gran
    assign gran_addr[g] = req_addr + ADDR_W'(GRAN_BYTES * g);
    assign gran_live[g] = int'(req_len) > int'(GRAN_BYTES * g);
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_region
    if (e == 0) begin : g_first
      assign ent_base[e] = '0;
    end else begin : g_next
      assign ent_base[e] = ent_addr[e-1];
    end

    pmp_region_match #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_match (
      .mode      (ent_cfg[e].mode),
      .top_reg   (ent_addr[e]),
      .base_reg  (ent_base[e]),
      .gran_addr (gran_addr),
      .gran_live (gran_live),
      .any_hit   (any_vec[e]),
      .all_hit   (all_vec[e])
    );
  end

  pmp_decide #(.ENTRIES(ENTRIES)) u_decide (
    .any_vec (any_vec),
    .all_vec (all_vec),
    .ent_cfg (ent_cfg),
    .priv_m  (req_priv_m),
    .kind    (acc_kind_e'(req_kind)),
    .win_vec (win_vec),
    .allow   (dec_allow)
  );

  // R10
  assign nxt_fault = !dec_allow;
  assign nxt_code  = dec_allow ? 4'd0 : DENY_CAUSE;
  assign nxt_faddr = dec_allow ? '0 : req_addr;

  if (REG_OUT) begin : g_reg
    logic              v_q;
    logic              allow_q;
    logic              fault_q;
    logic [3:0]        code_q;
    logic [ADDR_W-1:0] faddr_q;

    assign req_ready = !v_q || rsp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q     <= 1'b0;
        allow_q <= 1'b0;
        fault_q <= 1'b0;
        code_q  <= '0;
        faddr_q <= '0;
      end else if (req_ready) begin
        v_q <= req_valid;
        if (req_valid) begin
          allow_q <= dec_allow;
          fault_q <= nxt_fault;
          code_q  <= nxt_code;
          faddr_q <= nxt_faddr;
        end
      end
    end

    assign rsp_valid      = v_q;
    assign rsp_allow      = allow_q;
    assign rsp_fault      = fault_q;
    assign rsp_fault_code = code_q;
    assign rsp_fault_addr = faddr_q;

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_allow) && $stable(rsp_fault_addr)));

    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);
  end else begin : g_comb
    assign req_ready      = rsp_ready;
    assign rsp_valid      = req_valid;
    assign rsp_allow      = dec_allow;
    assign rsp_fault      = nxt_fault;
    assign rsp_fault_code = nxt_code;
    assign rsp_fault_addr = nxt_faddr;
  end

  p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  p_winner_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec & ~any_vec) == '0);

  p_partial_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_vec & ~all_vec) != '0) |-> !dec_allow);

  p_nomatch_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_vec == '0) |-> (dec_allow == req_priv_m));

endmodule

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_we = 1'b0;
  logic [3:0]  addr_sel = '0;
  logic [29:0] addr_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = 4'd4;
  logic [1:0]  req_kind = '0;
  logic        req_priv_m = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_allow;
  logic        rsp_fault;
  logic [3:0]  rsp_fault_code;
  logic [31:0] rsp_fault_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  pmp_checker u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_we(addr_we), .addr_sel(addr_sel), .addr_wdata(addr_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_kind(req_kind), .req_priv_m(req_priv_m),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_allow(rsp_allow),
    .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code),
    .rsp_fault_addr(rsp_fault_addr)
  );

  // {req tag, addr, len, kind, priv_m, expected allow}
  localparam int NV = 29;
  localparam logic [43:0] VECS [NV] = '{
    {4'd3,  32'h0000_0100, 4'd4, 2'd0, 1'b0, 1'b1}, // R3 region 0 read
    {4'd8,  32'h0000_0100, 4'd4, 2'd1, 1'b0, 1'b0}, // R8 no write bit
    {4'd8,  32'h0000_0100, 4'd4, 2'd1, 1'b1, 1'b1}, // R8 machine, unlocked
    {4'd6,  32'h0000_0FFC, 4'd8, 2'd0, 1'b0, 1'b0}, // R6 straddles top
    {4'd6,  32'h0000_0FFC, 4'd4, 2'd0, 1'b0, 1'b1}, // R6 single granule
    {4'd6,  32'h0000_0FFF, 4'd1, 2'd0, 1'b0, 1'b1}, // R6 one byte
    {4'd3,  32'h0000_1800, 4'd4, 2'd1, 1'b0, 1'b1}, // R3 region 1 window
    {4'd8,  32'h0000_1800, 4'd4, 2'd2, 1'b1, 1'b0}, // R8 locked, no X
    {4'd8,  32'h0000_1800, 4'd4, 2'd0, 1'b1, 1'b1}, // R8 locked, R set
    {4'd6,  32'h0000_1FFC, 4'd8, 2'd1, 1'b0, 1'b0}, // R6 partial window
    {4'd4,  32'h0000_3000, 4'd4, 2'd2, 1'b0, 1'b1}, // R4 word fetch
    {4'd4,  32'h0000_3000, 4'd4, 2'd0, 1'b1, 1'b0}, // R4 locked word read
    {4'd4,  32'h0000_3002, 4'd2, 2'd2, 1'b0, 1'b1}, // R4 inside word
    {4'd9,  32'h0000_3004, 4'd4, 2'd2, 1'b0, 1'b0}, // R9 next word, user
    {4'd9,  32'h0000_3004, 4'd4, 2'd2, 1'b1, 1'b1}, // R9 next word, machine
    {4'd5,  32'h0000_40F0, 4'd4, 2'd1, 1'b0, 1'b1}, // R5 256-byte block
    {4'd7,  32'h0000_40FC, 4'd8, 2'd0, 1'b0, 1'b0}, // R7 region 3 partial wins
    {4'd7,  32'h0000_4100, 4'd4, 2'd0, 1'b1, 1'b0}, // R7 falls to region 4
    {4'd5,  32'h0000_4FFC, 4'd4, 2'd0, 1'b0, 1'b0}, // R5 4 KiB block end
    {4'd5,  32'h0000_5000, 4'd4, 2'd0, 1'b1, 1'b1}, // R5 past block, machine
    {4'd9,  32'h0000_5000, 4'd4, 2'd0, 1'b0, 1'b0}, // R9 past block, user
    {4'd3,  32'h0000_6000, 4'd4, 2'd1, 1'b0, 1'b1}, // R3 base from off region
    {4'd12, 32'h0000_5FFC, 4'd4, 2'd1, 1'b0, 1'b0}, // R12 below base
    {4'd3,  32'h0000_6FFC, 4'd4, 2'd1, 1'b0, 1'b1}, // R3 last word
    {4'd3,  32'h0000_7000, 4'd4, 2'd1, 1'b0, 1'b0}, // R3 top excluded
    {4'd12, 32'h0000_6100, 4'd4, 2'd0, 1'b0, 1'b0}, // R12 off region R ignored
    {4'd12, 32'h0000_6100, 4'd4, 2'd0, 1'b1, 1'b1}, // R12 region 6 unlocked
    {4'd8,  32'h0000_0000, 4'd4, 2'd2, 1'b0, 1'b0}, // R8 fetch, R only
    {4'd5,  32'h0000_4000, 4'd8, 2'd2, 1'b0, 1'b1}  // R5 both granules inside
  };

  task automatic check(input int tag, input logic ev, input logic ea,
                       input logic [31:0] addr);
    logic [3:0]  ec;
    logic [31:0] efa;
    ec  = ea ? 4'd0 : 4'd1;
    efa = ea ? 32'h0 : addr;
    n_vec++;
    if (rsp_valid !== ev || (ev && (rsp_allow !== ea || rsp_fault !== !ea ||
        rsp_fault_code !== ec || rsp_fault_addr !== efa))) begin
      n_bad++;
      $display("FAIL R%0d addr=%h: got v=%b a=%b f=%b c=%0d fa=%h exp v=%b a=%b f=%b c=%0d fa=%h",
               tag, addr, rsp_valid, rsp_allow, rsp_fault, rsp_fault_code,
               rsp_fault_addr, ev, ea, !ea, ec, efa);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_addr(input logic [3:0] sel, input logic [29:0] d);
    @(negedge clk); addr_we = 1'b1; addr_sel = sel; addr_wdata = d;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input logic [3:0] l,
                       input logic [1:0] k, input logic p);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_kind = k; req_priv_m = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired: got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 1'b0, 32'h0);               // R1 nothing reported
    issue(32'h0000_0100, 4'd4, 2'd0, 1'b1);
    check(1, 1'b1, 1'b1, 32'h0000_0100);       // R1 machine allowed
    issue(32'h0000_0100, 4'd4, 2'd0, 1'b0);
    check(1, 1'b1, 1'b0, 32'h0000_0100);       // R1 user refused
    @(negedge clk); req_valid = 1'b0;

    // Region layout for the table (R2 byte packing)
    wr_addr(4'd0, 30'h0000_0400);
    wr_addr(4'd1, 30'h0000_0800);
    wr_addr(4'd2, 30'h0000_0C00);
    wr_addr(4'd3, 30'h0000_101F);
    wr_addr(4'd4, 30'h0000_11FF);
    wr_addr(4'd5, 30'h0000_1800);
    wr_addr(4'd6, 30'h0000_1C00);
    wr_cfg(2'd0, 32'h9F94_8B09);
    wr_cfg(2'd1, 32'h000A_0198);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i][39:8], VECS[i][7:4], VECS[i][3:2], VECS[i][1]);
      check(int'(VECS[i][43:40]), 1'b1, VECS[i][0], VECS[i][39:8]);
    end

    // R11 back-pressure: result held, request not taken
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 32'h0000_0100; req_len = 4'd4; req_kind = 2'd1; req_priv_m = 1'b0;
    #1;
    n_vec++;
    if (req_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 ready under stall: got %b exp 0", req_ready);
    end
    @(negedge clk);
    check(11, 1'b1, 1'b1, 32'h0000_4000);      // R11 old result frozen
    rsp_ready = 1'b1;
    @(negedge clk);
    check(11, 1'b1, 1'b0, 32'h0000_0100);      // R11 new result after release
    req_valid = 1'b0;
    @(negedge clk);
    check(11, 1'b0, 1'b0, 32'h0);              // R11 drains

    // R2: region 15 in byte 3 of register 3, reserved bits set and ignored
    wr_addr(4'd15, 30'h3FFF_FFFF);
    wr_cfg(2'd3, 32'hF900_0000);
    issue(32'h0000_5000, 4'd4, 2'd0, 1'b0);
    check(2, 1'b1, 1'b1, 32'h0000_5000);       // R2 whole-space read
    issue(32'h0000_5000, 4'd4, 2'd1, 1'b1);
    check(2, 1'b1, 1'b0, 32'h0000_5000);       // R2 lock applies to machine
    issue(32'h0000_0100, 4'd4, 2'd1, 1'b0);
    check(7, 1'b1, 1'b0, 32'h0000_0100);       // R7 region 0 still first
    issue(32'h0000_5000, 4'd4, 2'd3, 1'b0);
    check(8, 1'b1, 1'b0, 32'h0000_5000);       // R8 kind 3 has no permission
    req_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule